// File: doc/BRIEF.md
# Residue Signed-Digit to Binary Converter

This block takes a number held as three residues, one each for the moduli 2^n−1, 2^n and 2^n+1, and returns the plain unsigned binary integer X in [0, M), where M = (2^n−1)·2^n·(2^n+1). Each residue arrives as an n-digit radix-2 signed-digit vector. Each digit in {−1, 0, +1} is carried on a positive bit and a negative bit. This lets a carry-free residue datapath hand its results to ordinary binary logic.

The low n bits of X are the 2^n residue reduced to binary. The upper 2n bits come from a rearranged Chinese-remainder sum. Three 2n-digit vectors are built by pure wiring (negation, rotation and duplication). They are summed by two carry-free signed-digit adders that wrap modulo 2^(2n)−1. The signed-digit total is converted to binary twice in parallel: once as it is, and once after a carry-free addition of all-ones. The sign of the first conversion picks the result. The block is purely combinational and is parameterised by n, with n ≥ 3.

Top module: `rsd_to_bin`

## Requirements
- R1: Digit i of each residue has weight 2^i. The residue value is Σ(pos[i] − neg[i])·2^i, where pos=1/neg=0 means +1, pos=0/neg=1 means −1 and 0/0 means 0. The pair 1/1 is never applied. Any value in (−2^n, 2^n) is legal.
- R2: bin_o mod (2^n−1) equals the value of residue 1 mod (2^n−1).
- R3: bin_o[n-1:0] equals the value of residue 2 mod 2^n.
- R4: bin_o mod (2^n+1) equals the value of residue 3 mod (2^n+1).
- R5: bin_o is below M for every legal input, so that R2 to R4 pin it to a single integer.
- R6: The output depends only on the three residue values. Different digit encodings of one value give the same bin_o. So do non-canonical values such as r−m, r+m, or 2^n−1 standing for zero in the first modulus.
- R7: All-zero residues give 0. Residues all equal to −1 give M−1.
- R8: There is no state. bin_o follows the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x1_pos_i | input | N | Positive digit bits, residue mod 2^n−1 |
| x1_neg_i | input | N | Negative digit bits, residue mod 2^n−1 |
| x2_pos_i | input | N | Positive digit bits, residue mod 2^n |
| x2_neg_i | input | N | Negative digit bits, residue mod 2^n |
| x3_pos_i | input | N | Positive digit bits, residue mod 2^n+1 |
| x3_neg_i | input | N | Negative digit bits, residue mod 2^n+1 |
| bin_o | output | 3N | Binary integer in [0, M) |

## Verification
The bench builds the block with n = 4, so M = 4080 and every integer in the range can be swept. The sweep is done once with canonical plain-binary residues. It is done again with residues shifted by ±m and spread over random redundant digit patterns. At this size, rare cases come up in the sweep: the signed-digit sum landing at exactly ±(2^(2n)−1), digits of both signs, and the 2^n+1 residue 16, which can only be carried as −1. Single-digit weight probes and repeated re-encodings of one value complete the set.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

  typedef struct packed {
    logic t_pos;
    logic t_neg;
    logic w_pos;
    logic w_neg;
  } sd_split_t;

  function automatic logic signed [2:0] sd_digit(input logic p, input logic n);
    return $signed({2'b00, p}) - $signed({2'b00, n});
  endfunction

  // Split a digit-pair sum into transfer and interim digit so that the
  // interim plus incoming transfer never leaves {-1,0,1}.
  function automatic sd_split_t sd_split(input logic signed [2:0] s, input logic low_neg);
    sd_split_t r;
    r = '0;
    case (s)
      3'sd2:  r.t_pos = 1'b1;
      -3'sd2: r.t_neg = 1'b1;
      3'sd1:  if (!low_neg) begin r.t_pos = 1'b1; r.w_neg = 1'b1; end
              else r.w_pos = 1'b1;
      -3'sd1: if (!low_neg) r.w_neg = 1'b1;
              else begin r.t_neg = 1'b1; r.w_pos = 1'b1; end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic longint sd_val(input logic [63:0] p, input logic [63:0] n);
    return longint'(p) - longint'(n);
  endfunction

  function automatic longint pmod(input longint v, input longint m);
    return ((v % m) + m) % m;
  endfunction

endpackage

// File: rtl/rsd_mod_adder.sv
module rsd_mod_adder
  import rsd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_pos_i,
  input  logic [W-1:0] a_neg_i,
  input  logic [W-1:0] b_pos_i,
  input  logic [W-1:0] b_neg_i,
  output logic [W-1:0] s_pos_o,
  output logic [W-1:0] s_neg_o
);
  localparam longint MODK = (longint'(1) << W) - 1;

  sd_split_t split [W];

  for (genvar i = 0; i < W; i++) begin : g_split
    localparam int LO = (i == 0) ? W - 1 : i - 1;
    logic signed [2:0] dsum;
    logic              low_neg;
    assign dsum    = sd_digit(a_pos_i[i], a_neg_i[i]) + sd_digit(b_pos_i[i], b_neg_i[i]);
    assign low_neg = (a_neg_i[LO] & ~a_pos_i[LO]) | (b_neg_i[LO] & ~b_pos_i[LO]);
    assign split[i] = sd_split(dsum, low_neg);
  end

  // top transfer wraps to digit 0 (2^W == 1 mod 2^W-1)
  for (genvar i = 0; i < W; i++) begin : g_merge
    localparam int LO = (i == 0) ? W - 1 : i - 1;
    logic signed [2:0] dig;
    assign dig = sd_digit(split[i].w_pos, split[i].w_neg)
               + sd_digit(split[LO].t_pos, split[LO].t_neg);
    assign s_pos_o[i] = (dig == 3'sd1);
    assign s_neg_o[i] = (dig == -3'sd1);
  end

  always_comb begin
    if (!$isunknown({a_pos_i, a_neg_i, b_pos_i, b_neg_i})) begin
      assert_sum_congruent_R6: assert (pmod(sd_val(64'(s_pos_o), 64'(s_neg_o))
                                          - sd_val(64'(a_pos_i), 64'(a_neg_i))
                                          - sd_val(64'(b_pos_i), 64'(b_neg_i)), MODK) == 0)
        else $error("modular sum not congruent");
    end
  end

endmodule

// File: rtl/rsd_ones_adder.sv
module rsd_ones_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_pos_i,
  input  logic [W-1:0] x_neg_i,
  output logic [W-1:0] y_pos_o,
  output logic [W-1:0] y_neg_o
);
  localparam longint MOD2 = longint'(1) << W;
  localparam longint MODK = MOD2 - 1;

  logic [W-1:0] t_pos;
  logic [W-1:0] w_neg;

  for (genvar i = 0; i < W; i++) begin : g_dig
    logic t_in;
    assign t_pos[i] = ~(x_neg_i[i] & ~x_pos_i[i]);
    assign w_neg[i] = ~(x_pos_i[i] ^ x_neg_i[i]);
    if (i == 0) begin : g_lsb
      assign t_in = 1'b0;
    end else begin : g_up
      assign t_in = t_pos[i-1];
    end
    assign y_pos_o[i] = t_in & ~w_neg[i];
    assign y_neg_o[i] = w_neg[i] & ~t_in;
  end

  always_comb begin
    if (!$isunknown({x_pos_i, x_neg_i})) begin
      assert_ones_shift_R5: assert (rsd_pkg::pmod(
          rsd_pkg::sd_val(64'(y_pos_o), 64'(y_neg_o))
        - rsd_pkg::sd_val(64'(x_pos_i), 64'(x_neg_i)) - MODK, MOD2) == 0)
        else $error("all-ones addition wrong");
    end
  end

endmodule

// File: rtl/rsd_sd2bin.sv
module rsd_sd2bin #(
  parameter int W = 8
) (
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] neg_i,
  output logic [W:0]   diff_o
);
  assign diff_o = {1'b0, pos_i} - {1'b0, neg_i};
endmodule

// File: rtl/rsd_to_bin.sv
module rsd_to_bin
  import rsd_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]   x1_pos_i,
  input  logic [N-1:0]   x1_neg_i,
  input  logic [N-1:0]   x2_pos_i,
  input  logic [N-1:0]   x2_neg_i,
  input  logic [N-1:0]   x3_pos_i,
  input  logic [N-1:0]   x3_neg_i,
  output logic [3*N-1:0] bin_o
);
  localparam int     W    = 2 * N;
  localparam longint MLO  = (longint'(1) << N) - 1;
  localparam longint MMID = longint'(1) << N;
  localparam longint MHI  = (longint'(1) << N) + 1;
  localparam longint MTOT = MLO * MMID * MHI;
  localparam logic [W-1:0] K_ONES = '1;

  // low field: 2^n residue to binary
  logic [N:0]   low_diff;
  logic [N-1:0] low_bin;

  rsd_sd2bin #(.W(N)) u_low_conv (
    .pos_i (x2_pos_i),
    .neg_i (x2_neg_i),
    .diff_o(low_diff)
  );
  assign low_bin = low_diff[N-1:0];

  // wired operands: a = -(2^n*low + x3), b/c = 2^(n-1)(2^n+1)*x mod 2^(2n)-1
  logic [W-1:0] a_pos, a_neg, b_pos, b_neg, c_pos, c_neg;
  assign a_pos = {{N{1'b0}}, x3_neg_i};
  assign a_neg = {low_bin, x3_pos_i};
  assign b_pos = {x1_pos_i[0], x1_pos_i, x1_pos_i[N-1:1]};
  assign b_neg = {x1_neg_i[0], x1_neg_i, x1_neg_i[N-1:1]};
  assign c_pos = {x3_pos_i[0], x3_pos_i, x3_pos_i[N-1:1]};
  assign c_neg = {x3_neg_i[0], x3_neg_i, x3_neg_i[N-1:1]};

  logic [W-1:0] ab_pos, ab_neg, abc_pos, abc_neg;

  rsd_mod_adder #(.W(W)) u_add_ab (
    .a_pos_i(a_pos), .a_neg_i(a_neg),
    .b_pos_i(b_pos), .b_neg_i(b_neg),
    .s_pos_o(ab_pos), .s_neg_o(ab_neg)
  );

  rsd_mod_adder #(.W(W)) u_add_abc (
    .a_pos_i(ab_pos), .a_neg_i(ab_neg),
    .b_pos_i(c_pos),  .b_neg_i(c_neg),
    .s_pos_o(abc_pos), .s_neg_o(abc_neg)
  );

  // corrected path: +(2^(2n)-1), converted alongside the raw path
  logic [W-1:0] cor_pos, cor_neg;

  rsd_ones_adder #(.W(W)) u_add_ones (
    .x_pos_i(abc_pos), .x_neg_i(abc_neg),
    .y_pos_o(cor_pos), .y_neg_o(cor_neg)
  );

  logic [W:0] raw_diff, cor_diff;

  rsd_sd2bin #(.W(W)) u_raw_conv (
    .pos_i(abc_pos), .neg_i(abc_neg), .diff_o(raw_diff)
  );

  rsd_sd2bin #(.W(W)) u_cor_conv (
    .pos_i(cor_pos), .neg_i(cor_neg), .diff_o(cor_diff)
  );

  logic [W-1:0] high_bin;
  always_comb begin
    if (raw_diff[W])                      high_bin = cor_diff[W-1:0];
    else if (raw_diff[W-1:0] == K_ONES)   high_bin = '0;  // +K is zero
    else                                  high_bin = raw_diff[W-1:0];
  end

  assign bin_o = {high_bin, low_bin};

  always_comb begin
    if (!$isunknown({x1_pos_i, x1_neg_i, x2_pos_i, x2_neg_i, x3_pos_i, x3_neg_i})) begin
      assert_mod_lo_R2: assert (pmod(longint'(bin_o), MLO)
                               == pmod(sd_val(64'(x1_pos_i), 64'(x1_neg_i)), MLO))
        else $error("residue 1 mismatch");
      assert_low_field_R3: assert (longint'(bin_o[N-1:0])
                                  == pmod(sd_val(64'(x2_pos_i), 64'(x2_neg_i)), MMID))
        else $error("residue 2 mismatch");
      assert_mod_hi_R4: assert (pmod(longint'(bin_o), MHI)
                               == pmod(sd_val(64'(x3_pos_i), 64'(x3_neg_i)), MHI))
        else $error("residue 3 mismatch");
      assert_in_range_R5: assert (longint'(bin_o) < MTOT)
        else $error("output outside range");
    end
  end

endmodule

// File: tb/test_rsd_to_bin.sv
module test_rsd_to_bin;
  localparam int N  = 4;
  localparam int M1 = (1 << N) - 1;
  localparam int M2 = 1 << N;
  localparam int M3 = (1 << N) + 1;
  localparam int MM = M1 * M2 * M3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]   x1p, x1n, x2p, x2n, x3p, x3n;
  logic [3*N-1:0] bin;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  rsd_to_bin #(.N(N)) i_rsd_to_bin (
    .x1_pos_i(x1p), .x1_neg_i(x1n),
    .x2_pos_i(x2p), .x2_neg_i(x2n),
    .x3_pos_i(x3p), .x3_neg_i(x3n),
    .bin_o(bin)
  );

  function automatic int nm(input int v, input int m);
    return ((v % m) + m) % m;
  endfunction

  function automatic int crt(input int v1, input int v2, input int v3);
    for (int x = 0; x < MM; x++)
      if (nm(x, M1) == nm(v1, M1) && nm(x, M2) == nm(v2, M2) && nm(x, M3) == nm(v3, M3))
        return x;
    return -1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // R1 encoding: value v as random redundant pos/neg vectors
  task automatic enc(input int v, input bit rnd, output logic [N-1:0] p, output logic [N-1:0] q);
    int lo, hi, r, pp;
    logic [N-1:0] c;
    lo = (v < 0) ? -v : 0;
    hi = (1 << N) - 1 - ((v > 0) ? v : 0);
    r  = rnd ? int'($urandom_range(hi, lo)) : lo;
    pp = v + r;
    p = pp[N-1:0];
    q = r[N-1:0];
    c = p & q;
    p = p & ~c;
    q = q & ~c;
  endtask

  task automatic pick(input int x, input int m, input bit alt, output int v);
    int cand [3];
    int cnt;
    v = x % m;
    cnt = 0;
    if (v < (1 << N)) begin cand[cnt] = v; cnt++; end
    if (alt) begin
      if (v - m > -(1 << N)) begin cand[cnt] = v - m; cnt++; end
      if (v + m < (1 << N))  begin cand[cnt] = v + m; cnt++; end
    end
    if (cnt == 0) v = v - m;
    else v = cand[$urandom_range(cnt - 1, 0)];
  endtask

  task automatic drive(input int v1, input int v2, input int v3, input bit rnd);
    enc(v1, rnd, x1p, x1n);
    enc(v2, rnd, x2p, x2n);
    enc(v3, rnd, x3p, x3n);
  endtask

  task automatic apply_x(input int x, input bit alt, input bit rnd, input string tag);
    int v1, v2, v3;
    pick(x, M1, alt, v1);
    pick(x, M2, alt, v2);
    pick(x, M3, alt, v3);
    @(posedge clk); #1;
    drive(v1, v2, v3, rnd);
    @(negedge clk);
    chk({tag, " R2 mod lo"}, nm(int'(bin), M1), nm(v1, M1));
    chk({tag, " R3 low bits"}, int'(bin[N-1:0]), nm(v2, M2));
    chk({tag, " R4 mod hi"}, nm(int'(bin), M3), nm(v3, M3));
    chk({tag, " R5 value"}, int'(bin), x);
  endtask

  task automatic t_zero_and_minus_one;
    @(posedge clk); #1;
    drive(0, 0, 0, 1'b0);
    @(negedge clk);
    chk("R7 zero", int'(bin), 0);
    @(posedge clk); #1;
    drive(-1, -1, -1, 1'b0);
    @(negedge clk);
    chk("R7 minus one", int'(bin), MM - 1);
  endtask

  task automatic t_digit_weights;
    for (int k = 0; k < N; k++) begin
      @(posedge clk); #1;
      x1p = '0; x1n = '0; x2p = '0; x2n = '0; x3p = '0; x3n = '0;
      x1n[k] = 1'b1;
      x2p[k] = 1'b1;
      x3n[k] = 1'b1;
      @(negedge clk);
      chk("R1 digit weight", int'(bin), crt(-(1 << k), 1 << k, -(1 << k)));
    end
  endtask

  task automatic t_canonical_sweep;
    for (int x = 0; x < MM; x++) apply_x(x, 1'b0, 1'b0, "canon");
  endtask

  task automatic t_redundant_sweep;
    for (int x = 0; x < MM; x++) apply_x(x, 1'b1, 1'b1, "R6 redundant");
  endtask

  task automatic t_same_value_encodings;
    int ref_v;
    for (int j = 0; j < 16; j++) begin
      @(posedge clk); #1;
      drive(M1, 11 - M2, M3 - 4, 1'b1);
      @(negedge clk);
      if (j == 0) ref_v = int'(bin);
      chk("R6 re-encoding", int'(bin), ref_v);
    end
    chk("R6 re-encoding value", ref_v, crt(0, 11, -4));
  endtask

  task automatic t_comb_settle;
    @(posedge clk); #1;
    drive(3, 5, 7, 1'b1);
    #2;
    chk("R8 settle a", int'(bin), crt(3, 5, 7));
    drive(-7, 9, -2, 1'b1);
    #2;
    chk("R8 settle b", int'(bin), crt(-7, 9, -2));
  endtask

  initial begin
    x1p = '0; x1n = '0; x2p = '0; x2n = '0; x3p = '0; x3n = '0;
    #2;
    chk("R7 reset state", int'(bin), 0);
    t_zero_and_minus_one();
    t_digit_weights();
    t_same_value_encodings();
    t_comb_settle();
    t_canonical_sweep();
    t_redundant_sweep();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule